// File: doc/BRIEF.md
# Backplane Slave Strobe-Cycle Sequencer

This block is the handshake engine of a backplane bus slave. It runs one I/O cycle for each data-strobe pulse. A raw strobe level is resynchronised and then starts a fixed sequence:

- an address-latch clock pulse;
- a settling state;
- a decision on whether the latched address selects this card's geographic slot.

A selected cycle gets a one-clock read/write strobe for the local data path. It then drives the transfer acknowledge until the master releases the strobe. An unselected cycle still waits for the strobe to release, but keeps acknowledge low throughout.

The address latch, data path and register file sit outside the block. The block only sees the latched address bits and the active-low slot pins. An active-low system reset from the backplane goes through its own synchroniser. When it takes effect, it forces the sequencer back to idle whatever it is doing. The current state is exposed as a one-hot vector.

The block has no data stream of its own. Every pin is a plain control or status level, so no valid/ready flow control applies.

Top module: `strobe_cycle_seq`

## Requirements
- R1: While `rst_n` is low, `state_o` is 6'b000001 (idle), `quiet_o` is 1, and `valid_o`, `latch_clk_o`, `ack_drv_o` and `io_stb_o` are 0.
- R2: `strobe_i` passes through a 3-flop synchroniser. A rise set up before clock edge E1 moves the machine from idle to the first latch state at edge E4, and never earlier.
- R3: In the first latch state (`state_o` bit 1), `latch_clk_o` is 1 and `quiet_o` is 0. The next edge always moves the machine to the second latch state (bit 2), where `latch_clk_o` is 0.
- R4: `valid_o` is loaded only at the edge that leaves the first latch state. It is loaded with 1 when `addr_i[22:18]` equals `~slot_n_i`, with bit 22 compared against `slot_n_i[4]` (so slot pins 10000 match field 01111). Otherwise `valid_o` holds its value, except that it is cleared by a system reset.
- R5: From the second latch state with `valid_o` = 1, the machine enters the first I/O state (bit 3) for exactly one clock. `io_stb_o` is high there, and the next edge goes to the second I/O state (bit 4).
- R6: From the second latch state with `valid_o` = 0, the machine goes straight to the second I/O state with `quiet_o` set to 1. `ack_drv_o` stays 0 for the whole cycle.
- R7: `ack_drv_o` is 1 exactly when the machine is in the second I/O state with `valid_o` = 1. The machine stays in that state while the synchronised strobe is high, and moves to set-quiescent (bit 5) on the first edge at which it is low.
- R8: In set-quiescent, `ack_drv_o` is 0 and `quiet_o` is 1, and the next edge returns the machine to idle.
- R9: `sys_rst_n_i` passes through a 3-flop synchroniser. A low level set up before edge E1 forces idle, `quiet_o` = 1 and `valid_o` = 0 at edge E4. While the reset stays in effect, strobe activity is ignored and the state remains idle.
- R10: `state_o` always has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus-side clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| strobe_i | input | 1 | Raw data-strobe level, active high |
| sys_rst_n_i | input | 1 | Raw backplane system reset, active low |
| slot_n_i | input | 5 | Geographic slot pins, active low |
| addr_i | input | 24 | Latched address; bits 22:18 carry the slot field |
| state_o | output | 6 | One-hot state: idle, latch A, latch B, I/O A, I/O B, set-quiescent |
| latch_clk_o | output | 1 | Address-latch clock pulse |
| ack_drv_o | output | 1 | Transfer-acknowledge drive enable |
| io_stb_o | output | 1 | One-clock read/write strobe |
| quiet_o | output | 1 | Quiescent indicator |
| valid_o | output | 1 | Registered slot-match result for the current cycle |

## Verification
A corrupted state register shows up at once on `state_o`. It also distorts `latch_clk_o`, `io_stb_o` or `ack_drv_o` in the same cycle, because those outputs are decoded directly from the state bits.

A wrong valid flag shows up in two ways:
- one clock after the second latch state, as the machine taking the I/O path it should have skipped;
- as an acknowledge that appears or stays missing until the strobe releases.

An error in a synchroniser depth shifts the departure from idle, or the forced return to idle, by whole clocks. The bench therefore compares every port against its cycle model on every clock.

// File: rtl/scs_pkg.sv
package scs_pkg;
  localparam int NUM_ST  = 6;
  localparam int ST_IDLE = 0;
  localparam int ST_LATA = 1;
  localparam int ST_LATB = 2;
  localparam int ST_IOA  = 3;
  localparam int ST_IOB  = 4;
  localparam int ST_SETQ = 5;

  typedef logic [NUM_ST-1:0] st_vec_t;

  localparam st_vec_t IDLE_VEC = st_vec_t'(1) << ST_IDLE;
endpackage

// File: rtl/scs_sync.sv
module scs_sync #(
  parameter int   DEPTH   = 3,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [DEPTH-1:0] stage;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage[g] <= RST_VAL;
        end else if (g == 0) begin
          stage[g] <= d;
        end else begin
          stage[g] <= stage[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  assign q = stage[DEPTH-1];
endmodule

// File: rtl/scs_slot_match.sv
module scs_slot_match #(
  parameter int ADDR_W   = 24,
  parameter int SLOT_LSB = 18,
  parameter int SLOT_W   = 5
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SLOT_W-1:0] slot_n,
  output logic              hit
);
  logic [SLOT_W-1:0] field;

  assign field = addr[SLOT_LSB +: SLOT_W];
  assign hit   = (field == ~slot_n);
endmodule

// File: rtl/scs_fsm.sv
module scs_fsm
  import scs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    force_idle,
  input  logic    strobe,
  input  logic    hit,
  output st_vec_t state,
  output logic    valid,
  output logic    quiet
);
  st_vec_t state_nx;
  logic    valid_nx;
  logic    quiet_nx;

  always_comb begin
    state_nx = state;
    valid_nx = valid;
    quiet_nx = quiet;
    if (force_idle) begin
      state_nx = IDLE_VEC;
      valid_nx = 1'b0;
      quiet_nx = 1'b1;
    end else if ($countones(state) != 1) begin
      state_nx = IDLE_VEC;
      quiet_nx = 1'b1;
    end else begin
      state_nx = '0;
      unique case (1'b1)
        state[ST_IDLE]: begin
          if (strobe) begin
            state_nx[ST_LATA] = 1'b1;
            quiet_nx          = 1'b0;
          end else begin
            state_nx[ST_IDLE] = 1'b1;
          end
        end
        state[ST_LATA]: begin
          state_nx[ST_LATB] = 1'b1;
          valid_nx          = hit;
        end
        state[ST_LATB]: begin
          if (valid) begin
            state_nx[ST_IOA] = 1'b1;
          end else begin
            state_nx[ST_IOB] = 1'b1;
            quiet_nx         = 1'b1;
          end
        end
        state[ST_IOA]: begin
          state_nx[ST_IOB] = 1'b1;
        end
        state[ST_IOB]: begin
          if (strobe) begin
            state_nx[ST_IOB] = 1'b1;
          end else begin
            state_nx[ST_SETQ] = 1'b1;
            quiet_nx          = 1'b1;
          end
        end
        state[ST_SETQ]: begin
          state_nx[ST_IDLE] = 1'b1;
          quiet_nx          = 1'b1;
        end
        default: state_nx = IDLE_VEC;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= IDLE_VEC;
      valid <= 1'b0;
      quiet <= 1'b1;
    end else begin
      state <= state_nx;
      valid <= valid_nx;
      quiet <= quiet_nx;
    end
  end
endmodule

// File: rtl/strobe_cycle_seq.sv
module strobe_cycle_seq
  import scs_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int SLOT_LSB   = 18,
  parameter int SLOT_W     = 5,
  parameter int STB_SYNC   = 3,
  parameter int RST_SYNC   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_i,
  input  logic              sys_rst_n_i,
  input  logic [SLOT_W-1:0] slot_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NUM_ST-1:0] state_o,
  output logic              latch_clk_o,
  output logic              ack_drv_o,
  output logic              io_stb_o,
  output logic              quiet_o,
  output logic              valid_o
);
  logic    strobe_s;
  logic    sys_rst_n_s;
  logic    sys_rst_act;
  logic    hit;
  st_vec_t state;

  scs_sync #(.DEPTH(STB_SYNC), .RST_VAL(1'b0)) u_stb_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (strobe_i),
    .q     (strobe_s)
  );

  scs_sync #(.DEPTH(RST_SYNC), .RST_VAL(1'b1)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (sys_rst_n_i),
    .q     (sys_rst_n_s)
  );

  assign sys_rst_act = ~sys_rst_n_s;

  scs_slot_match #(.ADDR_W(ADDR_W), .SLOT_LSB(SLOT_LSB), .SLOT_W(SLOT_W)) u_match (
    .addr   (addr_i),
    .slot_n (slot_n_i),
    .hit    (hit)
  );

  scs_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .force_idle (sys_rst_act),
    .strobe     (strobe_s),
    .hit        (hit),
    .state      (state),
    .valid      (valid_o),
    .quiet      (quiet_o)
  );

  assign state_o     = state;
  assign latch_clk_o = state[ST_LATA];
  assign io_stb_o    = state[ST_IOA];
  assign ack_drv_o   = state[ST_IOB] & valid_o;
endmodule

// File: rtl/strobe_cycle_seq_chk.sv
module strobe_cycle_seq_chk
  import scs_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sys_rst_act,
  input logic [NUM_ST-1:0] state_o,
  input logic              latch_clk_o,
  input logic              ack_drv_o,
  input logic              io_stb_o,
  input logic              quiet_o,
  input logic              valid_o
);
  assert_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(state_o) == 1);

  assert_lat_seq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_clk_o && !sys_rst_act) |=> (state_o[ST_LATB] && !latch_clk_o));

  assert_lat_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    latch_clk_o |-> !quiet_o);

  assert_valid_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!state_o[ST_LATA] && !sys_rst_act) |=> $stable(valid_o));

  assert_ioa_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (io_stb_o && !sys_rst_act) |=> (state_o[ST_IOB] && !io_stb_o));

  assert_skip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o[ST_LATB] && !valid_o && !sys_rst_act) |=> (state_o[ST_IOB] && quiet_o && !ack_drv_o));

  assert_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_drv_o |-> (state_o[ST_IOB] && valid_o));

  assert_setq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o[ST_SETQ] && !sys_rst_act) |=> state_o[ST_IDLE]);

  assert_setq_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
    state_o[ST_SETQ] |-> (quiet_o && !ack_drv_o));

  assert_sysrst_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_act |=> (state_o[ST_IDLE] && quiet_o && !valid_o && !ack_drv_o));
endmodule

bind strobe_cycle_seq strobe_cycle_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sys_rst_act (sys_rst_act),
  .state_o     (state_o),
  .latch_clk_o (latch_clk_o),
  .ack_drv_o   (ack_drv_o),
  .io_stb_o    (io_stb_o),
  .quiet_o     (quiet_o),
  .valid_o     (valid_o)
);

// File: tb/tb_strobe_cycle_seq.sv
module tb_strobe_cycle_seq;
  localparam int CLK_PERIOD = 10;
  localparam int IDLE = 0, LATA = 1, LATB = 2, IOA = 3, IOB = 4, SETQ = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        strobe_i;
  logic        sys_rst_n_i;
  logic [4:0]  slot_n_i;
  logic [23:0] addr_i;
  logic [5:0]  state_o;
  logic        latch_clk_o, ack_drv_o, io_stb_o, quiet_o, valid_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // reference model state
  logic [5:0] m_state;
  logic       m_valid, m_quiet;
  logic [2:0] m_stb;
  logic [2:0] m_rst;

  always #(CLK_PERIOD/2) clk = ~clk;

  strobe_cycle_seq dut (
    .clk(clk), .rst_n(rst_n), .strobe_i(strobe_i), .sys_rst_n_i(sys_rst_n_i),
    .slot_n_i(slot_n_i), .addr_i(addr_i), .state_o(state_o),
    .latch_clk_o(latch_clk_o), .ack_drv_o(ack_drv_o), .io_stb_o(io_stb_o),
    .quiet_o(quiet_o), .valid_o(valid_o)
  );

  function automatic logic slot_hit(input logic [23:0] a, input logic [4:0] s);
    return a[22:18] == ~s;
  endfunction

  function automatic logic [5:0] oh(input int i);
    return 6'(1) << i;
  endfunction

  task automatic check(input string req, input string what, input logic [5:0] act, input logic [5:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_state = oh(IDLE); m_valid = 1'b0; m_quiet = 1'b1;
    m_stb = 3'b000; m_rst = 3'b111;
  endtask

  task automatic model_step();
    logic [5:0] ns;
    logic nv, nq;
    ns = m_state; nv = m_valid; nq = m_quiet;
    if (!m_rst[2]) begin
      ns = oh(IDLE); nv = 1'b0; nq = 1'b1;
    end else if (m_state[IDLE]) begin
      if (m_stb[2]) begin ns = oh(LATA); nq = 1'b0; end
    end else if (m_state[LATA]) begin
      ns = oh(LATB); nv = slot_hit(addr_i, slot_n_i);
    end else if (m_state[LATB]) begin
      if (m_valid) ns = oh(IOA);
      else begin ns = oh(IOB); nq = 1'b1; end
    end else if (m_state[IOA]) begin
      ns = oh(IOB);
    end else if (m_state[IOB]) begin
      if (!m_stb[2]) begin ns = oh(SETQ); nq = 1'b1; end
    end else begin
      ns = oh(IDLE); nq = 1'b1;
    end
    m_state = ns; m_valid = nv; m_quiet = nq;
    m_stb = {m_stb[1:0], strobe_i};
    m_rst = {m_rst[1:0], sys_rst_n_i};
  endtask

  task automatic compare_all();
    check("R10", "state", state_o, m_state);
    check("R3", "latch_clk", 6'(latch_clk_o), 6'(m_state[LATA]));
    check("R5", "io_stb", 6'(io_stb_o), 6'(m_state[IOA]));
    check("R7", "ack", 6'(ack_drv_o), 6'(m_state[IOB] & m_valid));
    check("R4", "valid", 6'(valid_o), 6'(m_valid));
    check("R6", "quiet", 6'(quiet_o), 6'(m_quiet));
  endtask

  // one clock: model advances at the edge, outputs compared at the falling edge
  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    rst_n = 1'b0; strobe_i = 1'b0; sys_rst_n_i = 1'b1;
    slot_n_i = 5'b10000; addr_i = 24'h000000 | (24'(5'b11111) << 18);
    model_reset();
    repeat (2) @(negedge clk);
    // R1: reset values
    check("R1", "state", state_o, 6'b000001);
    check("R1", "quiet", 6'(quiet_o), 6'd1);
    check("R1", "outs", {2'b0, valid_o, latch_clk_o, ack_drv_o, io_stb_o}, 6'd0);
    rst_n = 1'b1;
    tick();

    // Directed: cycle not for this card (R6, R2)
    strobe_i = 1'b1;
    for (int k = 1; k <= 4; k++) begin
      tick();
      if (k == 3) check("R2", "still idle after 3 edges", state_o, 6'b000001);
      if (k == 4) check("R2", "latch A after 4 edges", state_o, 6'b000010);
    end
    tick();
    check("R4", "no slot match", 6'(valid_o), 6'd0);
    tick();
    check("R6", "skip to IO B", state_o, 6'b010000);
    check("R6", "quiet raised", 6'(quiet_o), 6'd1);
    repeat (3) tick();
    check("R6", "no ack while waiting", 6'(ack_drv_o), 6'd0);
    strobe_i = 1'b0;
    repeat (8) tick();

    // Directed: cycle for this card (R4, R5, R7, R8)
    addr_i = 24'(5'b01111) << 18;
    strobe_i = 1'b1;
    repeat (5) tick();
    check("R4", "slot pins 10000 match 01111", 6'(valid_o), 6'd1);
    tick();
    check("R5", "IO A", state_o, 6'b001000);
    check("R5", "io strobe", 6'(io_stb_o), 6'd1);
    tick();
    check("R7", "ack high", 6'(ack_drv_o), 6'd1);
    addr_i = 24'h0;
    repeat (3) tick();
    check("R4", "valid held", 6'(valid_o), 6'd1);
    strobe_i = 1'b0;
    repeat (3) tick();
    check("R7", "still IO B before sync", state_o, 6'b010000);
    tick();
    check("R8", "set quiescent", state_o, 6'b100000);
    check("R8", "ack dropped", 6'(ack_drv_o), 6'd0);
    tick();
    check("R8", "back to idle", state_o, 6'b000001);
    repeat (3) tick();

    // Directed: system reset mid-cycle (R9)
    addr_i = 24'(5'b01111) << 18;
    strobe_i = 1'b1;
    repeat (7) tick();
    sys_rst_n_i = 1'b0;
    repeat (3) tick();
    check("R9", "not yet forced", 6'(state_o[IDLE]), 6'd0);
    tick();
    check("R9", "forced idle", state_o, 6'b000001);
    check("R9", "valid cleared", 6'(valid_o), 6'd0);
    repeat (5) tick();
    check("R9", "strobe ignored under reset", state_o, 6'b000001);
    sys_rst_n_i = 1'b1;
    strobe_i = 1'b0;
    repeat (6) tick();

    // Constrained random phase
    void'($urandom(32'h5C5_1234));
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 5) == 0) strobe_i = ~strobe_i;
      if (!sys_rst_n_i) begin
        if ($urandom_range(0, 2) == 0) sys_rst_n_i = 1'b1;
      end else if ($urandom_range(0, 199) == 0) sys_rst_n_i = 1'b0;
      if ($urandom_range(0, 7) == 0) slot_n_i = 5'($urandom);
      if ($urandom_range(0, 3) == 0) begin
        addr_i = 24'($urandom);
        if ($urandom_range(0, 1) == 0) addr_i[22:18] = ~slot_n_i;
      end
      tick();
    end

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule